// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits behind the bus-interface latches of a parallel NOR flash controller. Each accepted write cycle arrives as a 20-bit word address and a 16-bit data word. The block follows the multi-cycle unlock protocol that guards every array-altering command. The protocol has two key cycles, a command code, and for erases a second key pair followed by a final code. The block recognises the complete command set: word program, sector erase, block erase, chip erase, identification entry, query entry and the mode-exit command.

When a sequence completes, the block emits a one-cycle start pulse. The pulse carries the operation kind, the target address and, for a program, the data word. The array sequencer acts on these. The block also holds read-mode flags for identification and query reads, and it returns the identification words for the two identification addresses.

A malformed cycle cancels the sequence. In that case the block pulses an abort and falls back to plain array reads. The same happens when the target lies in the bottom sectors while protection is asserted. The block ignores writes while the array reports an operation in progress. The hardware reset clears any partial sequence.

Top module: `flashCmdDecoder`

## Requirements
- R1: After reset (rstN low), startPulse, abortPulse, idMode and queryMode are all 0.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then (A,D) produce startPulse=1 in the cycle after the fourth write. With it, opType=1 (program), opAddr=A and opData=D.
- R3: In key and command cycles only address bits 14..0 and data bits 7..0 are compared. Address bits 19..15 and data bits 15..8 may take any value.
- R4: The erase prefix is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. It is followed by 30h at address A, which gives opType=2 (sector erase), or by 50h at A, which gives opType=3 (block erase). In both cases opAddr=A and opData=0.
- R5: The erase prefix followed by 10h@5555h gives opType=4 (chip erase) with opAddr=0. opKeepBottom equals the inverse of the wpN level seen on that final write.
- R6: The prefix AAh@5555h, 55h@2AAAh followed by a third write at 5555h selects a read mode. Code 90h sets idMode, code 98h sets queryMode, and code F0h clears both. At most one flag is set at a time.
- R7: While idMode=1, idWord reads 00BFh at rdAddr=0 and 2761h at rdAddr=1. It reads 0 at any other address and whenever idMode=0.
- R8: A write that does not continue the current sequence gives abortPulse=1 for exactly the next cycle. It also clears idMode and queryMode and restarts the sequence from its first cycle, with no start pulse.
- R9: With wpN=0 on the final write, three targets are refused. These are a program or sector erase whose address bits 19..10 are below 4, and a block erase of the block whose address bits 19..15 are 0. A refused target gives abortPulse=1 and no start pulse.
- R10: While busy=1, write cycles leave the sequence position and the read mode unchanged and produce no pulse. This includes the mode-exit command.
- R11: Asserting rstN low in the middle of a sequence discards the cycles already taken.
- R12: startPulse and abortPulse are never high together, and startPulse never lasts two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to plain read mode |
| wrValid | input | 1 | One latched bus write cycle is presented this clock |
| wrAddr | input | 20 | Word address of the write cycle |
| wrData | input | 16 | Data word of the write cycle |
| wpN | input | 1 | Low protects the bottom four sectors |
| busy | input | 1 | Array operation in progress; writes are ignored |
| rdAddr | input | 20 | Word address of the current read, for identification words |
| startPulse | output | 1 | One-cycle start of an array operation |
| opType | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| opAddr | output | 20 | Target address of the operation (0 for chip erase) |
| opData | output | 16 | Program data (0 for erases) |
| opKeepBottom | output | 1 | Protected sectors must be skipped by the operation |
| abortPulse | output | 1 | One-cycle return to read mode after a bad cycle |
| idMode | output | 1 | Identification read mode is active |
| queryMode | output | 1 | Query read mode is active |
| idWord | output | 16 | Identification word for rdAddr while idMode is set |

## Verification
The decoder registers startPulse, abortPulse, the operation fields and both mode flags. They all change on the same rising edge that accepts the decisive write, so they are due exactly one cycle after that write is presented. idWord is combinational from rdAddr and the mode flag, so it is valid in the same cycle. The bench presents each write on a falling edge and samples on the following falling edge, which is the first point where the registered result is stable. It checks the cycle after that as well, to confirm the pulse has dropped. Corrupted sequences are cut off at the bad cycle, so the abort is observed in the cycle that write is due.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROGRAM = 3'd1,
    OP_SECTOR  = 3'd2,
    OP_BLOCK   = 3'd3,
    OP_CHIP    = 3'd4
  } opKind_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_ID    = 2'd1,
    MODE_QUERY = 2'd2
  } rdMode_e;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_SETUP  = 8'h80;
  localparam logic [7:0] CODE_IDENT  = 8'h90;
  localparam logic [7:0] CODE_QUERY  = 8'h98;
  localparam logic [7:0] CODE_EXIT   = 8'hF0;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_BLOCK  = 8'h50;
  localparam logic [7:0] CODE_CHIP   = 8'h10;

  // control -> datapath strobes
  typedef struct packed {
    logic    load;
    opKind_e kind;
  } opStrobe_t;

  // datapath -> control comparison results for the current write
  typedef struct packed {
    logic       keyA;       // first key cycle matched
    logic       keyB;       // second key cycle matched
    logic       atCmdAddr;  // address matches the command address
    logic [7:0] cmdByte;    // low data byte
    logic       secProt;    // target sector is write-protected
    logic       blkProt;    // target block holds protected sectors
  } matchFlags_t;

endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int CMP_W        = 15,
  parameter int SECTOR_LSB   = 10,
  parameter int BLOCK_LSB    = 15,
  parameter int PROT_SECTORS = 4,
  parameter logic [CMP_W-1:0]  KEY_ADDR_A = 15'h5555,
  parameter logic [CMP_W-1:0]  KEY_ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] MFR_CODE   = 16'h00BF,
  parameter logic [DATA_W-1:0] DEV_CODE   = 16'h2761
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpN,
  input  opStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              idMode,
  output matchFlags_t       flags,
  output opKind_e           opType,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              opKeepBottom,
  output logic [DATA_W-1:0] idWord
);

  localparam int SEC_W    = ADDR_W - SECTOR_LSB;
  localparam int BLK_SPAN = BLOCK_LSB - SECTOR_LSB;
  localparam logic [SEC_W-1:0] BLK_MASK  = ~(SEC_W'((1 << BLK_SPAN) - 1));
  localparam logic [SEC_W-1:0] PROT_LIM  = SEC_W'(PROT_SECTORS);

  logic [SEC_W-1:0] secIdx;
  logic [SEC_W-1:0] blkFirstSec;
  logic             addrIsA;
  logic             addrIsB;

  assign secIdx      = wrAddr[ADDR_W-1:SECTOR_LSB];
  assign blkFirstSec = secIdx & BLK_MASK;
  assign addrIsA     = (wrAddr[CMP_W-1:0] == KEY_ADDR_A);
  assign addrIsB     = (wrAddr[CMP_W-1:0] == KEY_ADDR_B);

  always_comb begin
    flags.cmdByte   = wrData[7:0];
    flags.atCmdAddr = addrIsA;
    flags.keyA      = addrIsA && (wrData[7:0] == CODE_KEY1);
    flags.keyB      = addrIsB && (wrData[7:0] == CODE_KEY2);
    flags.secProt   = !wpN && (secIdx < PROT_LIM);
    flags.blkProt   = !wpN && (blkFirstSec < PROT_LIM);
  end

  // operation descriptor, loaded on the decisive write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opType       <= OP_NONE;
      opAddr       <= '0;
      opData       <= '0;
      opKeepBottom <= 1'b0;
    end else if (strobe.load) begin
      opType       <= strobe.kind;
      opAddr       <= (strobe.kind == OP_CHIP) ? '0 : wrAddr;
      opData       <= (strobe.kind == OP_PROGRAM) ? wrData : '0;
      opKeepBottom <= !wpN;
    end
  end

  // identification words
  always_comb begin
    idWord = '0;
    if (idMode) begin
      if (rdAddr == '0)                 idWord = MFR_CODE;
      else if (rdAddr == ADDR_W'(1))    idWord = DEV_CODE;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        busy,
  input  matchFlags_t flags,
  output opStrobe_t   strobe,
  output logic        startPulse,
  output logic        abortPulse,
  output logic        idMode,
  output logic        queryMode
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERA1, ST_ERA2, ST_ERA3
  } seqState_e;

  seqState_e state, nxtState;
  rdMode_e   mode,  nxtMode;
  logic      doStart, doAbort, fail, take;

  assign take = wrValid && !busy;

  always_comb begin
    nxtState    = state;
    nxtMode     = mode;
    doStart     = 1'b0;
    fail        = 1'b0;
    strobe.load = 1'b0;
    strobe.kind = OP_NONE;
    if (take) begin
      unique case (state)
        ST_IDLE: if (flags.keyA) nxtState = ST_KEY1; else fail = 1'b1;
        ST_KEY1: if (flags.keyB) nxtState = ST_KEY2; else fail = 1'b1;
        ST_KEY2: begin
          if (!flags.atCmdAddr) fail = 1'b1;
          else begin
            unique case (flags.cmdByte)
              CODE_PROG:  nxtState = ST_PROG;
              CODE_SETUP: nxtState = ST_ERA1;
              CODE_IDENT: begin nxtState = ST_IDLE; nxtMode = MODE_ID;    end
              CODE_QUERY: begin nxtState = ST_IDLE; nxtMode = MODE_QUERY; end
              CODE_EXIT:  begin nxtState = ST_IDLE; nxtMode = MODE_READ;  end
              default:    fail = 1'b1;
            endcase
          end
        end
        ST_PROG: begin
          if (flags.secProt) fail = 1'b1;
          else begin
            strobe.load = 1'b1;
            strobe.kind = OP_PROGRAM;
          end
        end
        ST_ERA1: if (flags.keyA) nxtState = ST_ERA2; else fail = 1'b1;
        ST_ERA2: if (flags.keyB) nxtState = ST_ERA3; else fail = 1'b1;
        ST_ERA3: begin
          unique case (flags.cmdByte)
            CODE_SECTOR: if (flags.secProt) fail = 1'b1;
                         else begin strobe.load = 1'b1; strobe.kind = OP_SECTOR; end
            CODE_BLOCK:  if (flags.blkProt) fail = 1'b1;
                         else begin strobe.load = 1'b1; strobe.kind = OP_BLOCK; end
            CODE_CHIP:   if (!flags.atCmdAddr) fail = 1'b1;
                         else begin strobe.load = 1'b1; strobe.kind = OP_CHIP; end
            default:     fail = 1'b1;
          endcase
        end
        default: fail = 1'b1;
      endcase
      if (strobe.load) begin
        doStart  = 1'b1;
        nxtState = ST_IDLE;
        nxtMode  = MODE_READ;
      end
      if (fail) begin
        nxtState = ST_IDLE;
        nxtMode  = MODE_READ;
      end
    end
    doAbort = fail;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      mode       <= MODE_READ;
      startPulse <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      state      <= nxtState;
      mode       <= nxtMode;
      startPulse <= doStart;
      abortPulse <= doAbort;
    end
  end

  assign idMode    = (mode == MODE_ID);
  assign queryMode = (mode == MODE_QUERY);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse); // R12
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && abortPulse)); // R12
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!startPulse && !abortPulse && $stable(mode) && $stable(state))); // R10
  AST_ABORT_READ: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!idMode && !queryMode)); // R8

endmodule

// File: rtl/flashCmdDecoder.sv
module flashCmdDecoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int CMP_W        = 15,
  parameter int SECTOR_LSB   = 10,
  parameter int BLOCK_LSB    = 15,
  parameter int PROT_SECTORS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpN,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              startPulse,
  output logic [2:0]        opType,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              opKeepBottom,
  output logic              abortPulse,
  output logic              idMode,
  output logic              queryMode,
  output logic [DATA_W-1:0] idWord
);

  opStrobe_t   strobe;
  matchFlags_t flags;
  opKind_e     opKind;

  flash_cmd_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .busy       (busy),
    .flags      (flags),
    .strobe     (strobe),
    .startPulse (startPulse),
    .abortPulse (abortPulse),
    .idMode     (idMode),
    .queryMode  (queryMode)
  );

  flash_cmd_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CMP_W        (CMP_W),
    .SECTOR_LSB   (SECTOR_LSB),
    .BLOCK_LSB    (BLOCK_LSB),
    .PROT_SECTORS (PROT_SECTORS)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .wpN          (wpN),
    .strobe       (strobe),
    .rdAddr       (rdAddr),
    .idMode       (idMode),
    .flags        (flags),
    .opType       (opKind),
    .opAddr       (opAddr),
    .opData       (opData),
    .opKeepBottom (opKeepBottom),
    .idWord       (idWord)
  );

  assign opType = opKind;

  AST_PROT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && (opKind == OP_PROGRAM || opKind == OP_SECTOR))
      |-> !(!$past(wpN) && (opAddr[ADDR_W-1:SECTOR_LSB] < PROT_SECTORS))); // R9
  AST_PROG_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && opKind == OP_PROGRAM) |-> (opData == $past(wrData) && opAddr == $past(wrAddr))); // R2
  AST_CHIP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && opKind == OP_CHIP) |-> (opKeepBottom == !$past(wpN) && opAddr == '0)); // R5
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(idMode && queryMode)); // R6

endmodule

// File: tb/flashCmdDecoder_test.sv
`timescale 1ns/1ps
module flashCmdDecoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        wpN = 1'b1;
  logic        busy = 1'b0;
  logic [19:0] rdAddr = '0;
  logic        startPulse, opKeepBottom, abortPulse, idMode, queryMode;
  logic [2:0]  opType;
  logic [19:0] opAddr;
  logic [15:0] opData, idWord;

  int nChecks = 0;
  int nFails  = 0;
  int benchMode = 0; // 0 read, 1 id, 2 query

  always #5 clk = ~clk;

  flashCmdDecoder uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wpN(wpN), .busy(busy), .rdAddr(rdAddr), .startPulse(startPulse), .opType(opType),
    .opAddr(opAddr), .opData(opData), .opKeepBottom(opKeepBottom), .abortPulse(abortPulse),
    .idMode(idMode), .queryMode(queryMode), .idWord(idWord)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrCycle(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  function automatic logic [19:0] cmdAddr(input logic [14:0] low);
    return {5'($urandom), low};
  endfunction

  function automatic logic [15:0] cmdData(input logic [7:0] code);
    return {8'($urandom), code};
  endfunction

  // kinds: 0 program, 1 sector, 2 block, 3 chip, 4 ident, 5 query, 6 exit
  function automatic bit expStart(input int kind, input logic [19:0] a, input logic wp);
    case (kind)
      0, 1:    return !(!wp && a[19:10] < 10'd4);
      2:       return !(!wp && a[19:15] == 5'd0);
      3:       return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int expType(input int kind);
    return kind + 1;
  endfunction

  // sends a sequence; badIdx >= 0 corrupts that cycle and stops there
  task automatic sendCmd(input int kind, input logic [19:0] tgt, input logic [15:0] dat, input int badIdx);
    logic [19:0] aSeq[6];
    logic [15:0] dSeq[6];
    int n;
    aSeq[0] = cmdAddr(15'h5555); dSeq[0] = cmdData(8'hAA);
    aSeq[1] = cmdAddr(15'h2AAA); dSeq[1] = cmdData(8'h55);
    aSeq[2] = cmdAddr(15'h5555);
    case (kind)
      0:       dSeq[2] = cmdData(8'hA0);
      4:       dSeq[2] = cmdData(8'h90);
      5:       dSeq[2] = cmdData(8'h98);
      6:       dSeq[2] = cmdData(8'hF0);
      default: dSeq[2] = cmdData(8'h80);
    endcase
    n = 3;
    if (kind == 0) begin
      aSeq[3] = tgt; dSeq[3] = dat; n = 4;
    end else if (kind <= 3) begin
      aSeq[3] = cmdAddr(15'h5555); dSeq[3] = cmdData(8'hAA);
      aSeq[4] = cmdAddr(15'h2AAA); dSeq[4] = cmdData(8'h55);
      case (kind)
        1:       begin aSeq[5] = tgt; dSeq[5] = cmdData(8'h30); end
        2:       begin aSeq[5] = tgt; dSeq[5] = cmdData(8'h50); end
        default: begin aSeq[5] = cmdAddr(15'h5555); dSeq[5] = cmdData(8'h10); end
      endcase
      n = 6;
    end
    for (int i = 0; i < n; i++) begin
      if (i == badIdx) dSeq[i][7:0] = dSeq[i][7:0] ^ 8'h01;
      wrCycle(aSeq[i], dSeq[i]);
      if (i == badIdx) break;
    end
  endtask

  task automatic checkModes(input string req);
    check(idMode == (benchMode == 1), req, {31'd0, idMode}, (benchMode == 1));
    check(queryMode == (benchMode == 2), req, {31'd0, queryMode}, (benchMode == 2));
  endtask

  // runs one command and checks every result due after the final write
  task automatic runAndCheck(input int kind, input logic [19:0] tgt, input logic [15:0] dat,
                             input logic wp, input int badIdx);
    bit st;
    wpN = wp;
    sendCmd(kind, tgt, dat, badIdx);
    if (badIdx >= 0) begin
      benchMode = 0;
      check(abortPulse == 1'b1, "R8 abort on bad cycle", {31'd0, abortPulse}, 1);
      check(startPulse == 1'b0, "R8 no start on bad cycle", {31'd0, startPulse}, 0);
      checkModes("R8 read mode after abort");
    end else begin
      st = expStart(kind, tgt, wp);
      if (kind >= 4) begin
        benchMode = (kind == 4) ? 1 : (kind == 5) ? 2 : 0;
        check(!startPulse && !abortPulse, "R6 mode command pulses",
              {30'd0, startPulse, abortPulse}, 0);
        checkModes("R6 mode flags");
      end else begin
        benchMode = 0;
        check(startPulse == st, st ? "R2/R4/R5 start" : "R9 protected no start",
              {31'd0, startPulse}, {31'd0, st});
        check(abortPulse == !st, "R9 abort on protected target", {31'd0, abortPulse}, {31'd0, !st});
        if (st) begin
          check(opType == 3'(expType(kind)), "R2/R4/R5 opType", {29'd0, opType}, expType(kind));
          if (kind == 3) begin
            check(opAddr == 20'd0, "R5 chip opAddr", {12'd0, opAddr}, 0);
            check(opKeepBottom == !wp, "R5 keep bottom", {31'd0, opKeepBottom}, {31'd0, !wp});
          end else begin
            check(opAddr == tgt, "R2/R4 opAddr", {12'd0, opAddr}, {12'd0, tgt});
            check(opData == ((kind == 0) ? dat : 16'd0), "R2/R4 opData",
                  {16'd0, opData}, {16'd0, (kind == 0) ? dat : 16'd0});
          end
        end
        checkModes("R2 read mode after command");
      end
      @(negedge clk);
      check(!startPulse && !abortPulse, "R12 pulses last one cycle", {30'd0, startPulse, abortPulse}, 0);
    end
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!startPulse && !abortPulse && !idMode && !queryMode, "R1 reset state",
          {28'd0, startPulse, abortPulse, idMode, queryMode}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: each legal sequence
    runAndCheck(0, 20'hABCDE, 16'h1234, 1'b1, -1);
    runAndCheck(1, 20'h54321, 16'h0, 1'b1, -1);
    runAndCheck(2, 20'hF8000, 16'h0, 1'b1, -1);
    runAndCheck(3, 20'h0, 16'h0, 1'b0, -1);
    runAndCheck(3, 20'h0, 16'h0, 1'b1, -1);

    // R7 identification words
    runAndCheck(4, 20'h0, 16'h0, 1'b1, -1);
    rdAddr = 20'd0; #1;
    check(idWord == 16'h00BF, "R7 id word 0", {16'd0, idWord}, 32'h00BF);
    rdAddr = 20'd1; #1;
    check(idWord == 16'h2761, "R7 id word 1", {16'd0, idWord}, 32'h2761);
    rdAddr = 20'd2; #1;
    check(idWord == 16'h0000, "R7 id word other", {16'd0, idWord}, 0);

    // R10 exit ignored while busy
    busy = 1'b1;
    sendCmd(6, 20'h0, 16'h0, -1);
    check(idMode == 1'b1 && !abortPulse, "R10 exit ignored while busy",
          {30'd0, idMode, abortPulse}, 2);
    sendCmd(0, 20'h12345, 16'hBEEF, -1);
    check(!startPulse, "R10 program ignored while busy", {31'd0, startPulse}, 0);
    busy = 1'b0;
    runAndCheck(6, 20'h0, 16'h0, 1'b1, -1);
    rdAddr = 20'd0; #1;
    check(idWord == 16'h0000, "R7 id word cleared after exit", {16'd0, idWord}, 0);

    // R9 protection boundaries
    runAndCheck(0, 20'h00FFF, 16'h5A5A, 1'b0, -1);
    runAndCheck(0, 20'h01000, 16'h5A5A, 1'b0, -1);
    runAndCheck(1, 20'h00C00, 16'h0, 1'b0, -1);
    runAndCheck(2, 20'h07FFF, 16'h0, 1'b0, -1);
    runAndCheck(2, 20'h08000, 16'h0, 1'b0, -1);
    runAndCheck(0, 20'h00010, 16'h5A5A, 1'b1, -1);

    // R3 upper bits don't care: explicit
    wpN = 1'b1;
    wrCycle(20'hF5555, 16'hFFAA);
    wrCycle(20'h8AAAA, 16'h1255);
    wrCycle(20'h7D555, 16'h00A0);
    wrCycle(20'h33333, 16'hC0DE);
    check(startPulse && opAddr == 20'h33333, "R3 masked compare",
          {31'd0, startPulse}, 1);
    // R3: bit 14 is compared, so this is a bad first cycle
    wrCycle(20'h01555, 16'h00AA);
    check(abortPulse == 1'b1, "R3 bit 14 compared", {31'd0, abortPulse}, 1);

    // R11 reset mid-sequence
    wrCycle(20'h05555, 16'h00AA);
    wrCycle(20'h02AAA, 16'h0055);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(!idMode && !startPulse, "R11 reset state", {30'd0, idMode, startPulse}, 0);
    rstN = 1'b1;
    wrCycle(20'h05555, 16'h00A0);
    check(abortPulse && !startPulse, "R11 sequence discarded", {30'd0, abortPulse, startPulse}, 2);
    benchMode = 0;

    // random mix with corruption
    for (int it = 0; it < 300; it++) begin
      int kind, bad, ncyc;
      logic [19:0] tgt;
      logic [15:0] dat;
      logic wp;
      kind = int'($urandom % 7);
      tgt  = 20'($urandom);
      if ($urandom % 4 == 0) tgt = tgt & 20'h0FFFF;
      if ($urandom % 4 == 0) tgt = tgt & 20'h00FFF;
      dat  = 16'($urandom);
      wp   = 1'($urandom);
      ncyc = (kind == 0) ? 3 : (kind <= 3) ? 6 : 3;
      bad  = -1;
      if ($urandom % 3 == 0) bad = int'($urandom % ncyc);
      if (kind == 0 && bad == 3) bad = -1;
      runAndCheck(kind, tgt, dat, wp, bad);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule